// File: doc/BRIEF.md
# Serial Shift Interface with Edge Counter

This block is a flexible serial shifter for a small controller. An 8-bit data register moves one bit in from the data-in pin on each active clock edge, MSB first, while its top bit drives the data-out pin. A separate edge counter tracks clock edges, counting both edges so that 16 counts make one byte. It raises an overflow flag when it wraps. Software can read and preset the counter, so the flag can also serve as a one-shot event after any chosen number of edges.

The clock comes from one of two places. It can be the serial clock pin, sampled on a chosen polarity, or a software toggle strobe that also drives a clock output for master use. With the pin selected, software can route the toggle strobe to the counter alone, so the counter runs apart from the shifter. A wire-mode bit picks three-wire or two-wire output behaviour. In two-wire mode the data output turns into an open-drain pull-low control. A start condition on the lines sets a flag, and SCL is held low while the start or overflow flag is pending. The input paths are the same in both modes. Addressing and acknowledge policy stay in software.

Top module: `serial_shift_unit`

## Requirements
- R1: After reset the data register, counter, both flags, `sdo`, `sck_out`, `sda_low`, `scl_low` and `scl_hold` are all 0.
- R2: With `ext_clk`=1 and `ext_fall`=0, each rising edge of `sck_pin` shifts the data register left by one, loading `sdi_pin` into bit 0, so after 8 bits the register holds the byte sent MSB first.
- R3: With `ext_clk`=1 and `cnt_soft`=0, the counter goes up by one on every rising and every falling edge of `sck_pin`, so after 3 clock pulses it reads 6.
- R4: A counted event while the counter is 15 wraps it to 0 and sets `ovf_flag`. Presetting 15 therefore overflows on the very next edge.
- R5: A one-cycle `ovf_clr` pulse clears `ovf_flag`. If a wrap happens in the same cycle, the flag ends up set.
- R6: `cnt_wr` loads `cnt_wr_val` into the counter on the next clock, and it takes priority over a count event in the same cycle.
- R7: With `ext_clk`=0, each `tgl_stb` pulse inverts `sck_out` and adds one to the counter. The register shifts when `sck_out` goes from 0 to 1.
- R8: With `ext_clk`=1 and `cnt_soft`=1, `tgl_stb` adds one to the counter and changes neither `sck_out` nor the data register. `sck_pin` edges still shift but are no longer counted.
- R9: The data shifted in for a given pin sequence is the same with `two_wire`=1 as with `two_wire`=0.
- R10: With `two_wire`=1, a fall of `sdi_pin` while `sck_pin` is high sets `start_flag`, and `start_clr` clears it. With `two_wire`=0 the same lines never set it.
- R11: `scl_hold` and `scl_low` are 1 exactly while `two_wire`=1 and either flag is set (pin-clock mode). In three-wire mode both stay 0.
- R12: `sdo` always equals the register MSB. `sda_low` is 1 only when `two_wire`=1 and the MSB is 0.
- R13: With `ext_fall`=1 the shift happens on the falling edge of `sck_pin` and not on the rising edge.
- R14: `dr_wr` loads `dr_wr_val` into the data register on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sdi_pin | input | 1 | Serial data input (SDA in two-wire mode) |
| sck_pin | input | 1 | Serial clock input (SCL in two-wire mode) |
| two_wire | input | 1 | 1 selects two-wire output behaviour |
| ext_clk | input | 1 | 1 clocks the shifter from `sck_pin`, 0 from the toggle strobe |
| ext_fall | input | 1 | With the pin clock, 1 shifts on the falling edge |
| cnt_soft | input | 1 | With the pin clock, 1 makes the counter count toggle strobes only |
| tgl_stb | input | 1 | Software clock toggle strobe |
| cnt_wr | input | 1 | Counter load strobe |
| cnt_wr_val | input | CNT_W | Counter load value |
| dr_wr | input | 1 | Data register load strobe |
| dr_wr_val | input | DATA_W | Data register load value |
| ovf_clr | input | 1 | Clears the overflow flag |
| start_clr | input | 1 | Clears the start flag |
| sdo | output | 1 | Serial data out (register MSB) |
| sck_out | output | 1 | Software-generated clock level |
| sda_low | output | 1 | Pull SDA low (two-wire) |
| scl_low | output | 1 | Pull SCL low (two-wire) |
| scl_hold | output | 1 | SCL is held because a flag is pending |
| ovf_flag | output | 1 | Counter overflow flag |
| start_flag | output | 1 | Start condition flag |
| cnt_q | output | CNT_W | Counter value |
| dr_q | output | DATA_W | Data register value |

## Verification
The hardest state to reach is a counter wrap that lands in the same cycle as a counter load or a flag clear, because pin edges reach the counter only after a synchronizer delay. The bench avoids that delay by switching to the toggle-strobe clock. There it can line up `tgl_stb` with `ovf_clr` or `cnt_wr` in one chosen cycle, after presetting the counter to 15. Telling a start condition apart from ordinary data changes takes pin sequences that raise SCL first and only then drop SDA. The bench runs those in both wire modes, after random bytes have been shifted with SDA changing only while SCL is low.

// File: rtl/ssu_pkg.sv
package ssu_pkg;
  typedef enum logic {
    WIRE_THREE = 1'b0,
    WIRE_TWO   = 1'b1
  } wire_mode_e;

  typedef struct packed {
    logic shift;
    logic count;
  } ssu_event_t;
endpackage

// File: rtl/ssu_sync.sv
module ssu_sync #(
  parameter int W       = 1,
  parameter int STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[g] <= RST_VAL;
        else     stage_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[g] <= RST_VAL;
        else     stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/ssu_clk_ctl.sv
module ssu_clk_ctl
  import ssu_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       sck_s,
  input  logic       ext_clk,
  input  logic       ext_fall,
  input  logic       cnt_soft,
  input  logic       tgl_stb,
  output ssu_event_t ev_o,
  output logic       sw_clk_o
);
  logic sck_d;
  logic sw_clk_q;
  logic rise, fall, pin_edge, sw_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      sck_d    <= 1'b0;
      sw_clk_q <= 1'b0;
    end else begin
      sck_d <= sck_s;
      if (tgl_stb && !ext_clk) sw_clk_q <= ~sw_clk_q;
    end
  end

  always_comb begin
    rise     = sck_s & ~sck_d;
    fall     = ~sck_s & sck_d;
    pin_edge = ext_fall ? fall : rise;
    sw_rise  = tgl_stb & ~sw_clk_q;
    ev_o.shift = ext_clk ? pin_edge : sw_rise;
    if (!ext_clk)     ev_o.count = tgl_stb;
    else if (cnt_soft) ev_o.count = tgl_stb;
    else              ev_o.count = rise | fall;
  end

  assign sw_clk_o = sw_clk_q;
endmodule

// File: rtl/ssu_counter.sv
module ssu_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_ev,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_val,
  input  logic             ovf_clr,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;
  logic             wrap;

  assign wrap = cnt_ev && !wr_en && (cnt_q == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      if (wr_en)       cnt_q <= wr_val;
      else if (cnt_ev) cnt_q <= cnt_q + 1'b1;
      if (wrap)         ovf_q <= 1'b1;
      else if (ovf_clr) ovf_q <= 1'b0;
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;
endmodule

// File: rtl/ssu_shreg.sv
module ssu_shreg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shift_ev,
  input  logic              sdi_s,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_val,
  output logic [DATA_W-1:0] dr_o
);
  logic [DATA_W-1:0] dr_q;

  always_ff @(posedge clk) begin
    if (rst)           dr_q <= '0;
    else if (wr_en)    dr_q <= wr_val;
    else if (shift_ev) dr_q <= {dr_q[DATA_W-2:0], sdi_s};
  end

  assign dr_o = dr_q;
endmodule

// File: rtl/ssu_twowire.sv
module ssu_twowire
  import ssu_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  wire_mode_e mode,
  input  logic       sdi_s,
  input  logic       sck_s,
  input  logic       start_clr,
  input  logic       ovf_flag,
  input  logic       ext_clk,
  input  logic       sw_clk,
  input  logic       dr_msb,
  output logic       start_o,
  output logic       sda_low_o,
  output logic       scl_low_o,
  output logic       scl_hold_o
);
  logic sdi_d;
  logic start_q;
  logic start_seen;
  logic is_two;

  assign is_two     = (mode == WIRE_TWO);
  assign start_seen = is_two && sck_s && sdi_d && !sdi_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      sdi_d   <= 1'b0;
      start_q <= 1'b0;
    end else begin
      sdi_d <= sdi_s;
      if (start_seen)     start_q <= 1'b1;
      else if (start_clr) start_q <= 1'b0;
    end
  end

  assign start_o    = start_q;
  assign scl_hold_o = is_two && (start_q || ovf_flag);
  assign scl_low_o  = scl_hold_o || (is_two && !ext_clk && !sw_clk);
  assign sda_low_o  = is_two && !dr_msb;
endmodule

// File: rtl/serial_shift_unit.sv
module serial_shift_unit
  import ssu_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(2 * DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sdi_pin,
  input  logic              sck_pin,
  input  logic              two_wire,
  input  logic              ext_clk,
  input  logic              ext_fall,
  input  logic              cnt_soft,
  input  logic              tgl_stb,
  input  logic              cnt_wr,
  input  logic [CNT_W-1:0]  cnt_wr_val,
  input  logic              dr_wr,
  input  logic [DATA_W-1:0] dr_wr_val,
  input  logic              ovf_clr,
  input  logic              start_clr,
  output logic              sdo,
  output logic              sck_out,
  output logic              sda_low,
  output logic              scl_low,
  output logic              scl_hold,
  output logic              ovf_flag,
  output logic              start_flag,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [DATA_W-1:0] dr_q
);
  logic [1:0] pins_s;
  logic       sdi_s, sck_s;
  ssu_event_t ev;
  logic       shift_ev, cnt_ev;
  logic       sw_clk;
  wire_mode_e mode;

  assign mode = two_wire ? WIRE_TWO : WIRE_THREE;

  ssu_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({sdi_pin, sck_pin}),
    .q_o (pins_s)
  );
  assign sdi_s = pins_s[1];
  assign sck_s = pins_s[0];

  ssu_clk_ctl u_clk (
    .clk      (clk),
    .rst      (rst),
    .sck_s    (sck_s),
    .ext_clk  (ext_clk),
    .ext_fall (ext_fall),
    .cnt_soft (cnt_soft),
    .tgl_stb  (tgl_stb),
    .ev_o     (ev),
    .sw_clk_o (sw_clk)
  );
  assign shift_ev = ev.shift;
  assign cnt_ev   = ev.count;

  ssu_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .cnt_ev  (cnt_ev),
    .wr_en   (cnt_wr),
    .wr_val  (cnt_wr_val),
    .ovf_clr (ovf_clr),
    .cnt_o   (cnt_q),
    .ovf_o   (ovf_flag)
  );

  ssu_shreg #(.DATA_W(DATA_W)) u_shr (
    .clk      (clk),
    .rst      (rst),
    .shift_ev (shift_ev),
    .sdi_s    (sdi_s),
    .wr_en    (dr_wr),
    .wr_val   (dr_wr_val),
    .dr_o     (dr_q)
  );

  ssu_twowire u_tw (
    .clk        (clk),
    .rst        (rst),
    .mode       (mode),
    .sdi_s      (sdi_s),
    .sck_s      (sck_s),
    .start_clr  (start_clr),
    .ovf_flag   (ovf_flag),
    .ext_clk    (ext_clk),
    .sw_clk     (sw_clk),
    .dr_msb     (dr_q[DATA_W-1]),
    .start_o    (start_flag),
    .sda_low_o  (sda_low),
    .scl_low_o  (scl_low),
    .scl_hold_o (scl_hold)
  );

  assign sdo     = dr_q[DATA_W-1];
  assign sck_out = sw_clk;
endmodule

// File: rtl/serial_shift_unit_chk.sv
module serial_shift_unit_chk #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              cnt_ev,
  input logic              shift_ev,
  input logic              sdi_s,
  input logic              cnt_wr,
  input logic [CNT_W-1:0]  cnt_wr_val,
  input logic              dr_wr,
  input logic              ovf_clr,
  input logic              two_wire,
  input logic              start_flag,
  input logic              ovf_flag,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [DATA_W-1:0] dr_q
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  p_cnt_step_r3: assert property (@(posedge clk) disable iff (rst)
    (cnt_ev && !cnt_wr) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

  p_wrap_ovf_r4: assert property (@(posedge clk) disable iff (rst)
    (cnt_ev && !cnt_wr && cnt_q == CMAX) |=> (cnt_q == '0 && ovf_flag));

  p_ovf_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (ovf_clr && !(cnt_ev && !cnt_wr && cnt_q == CMAX)) |=> !ovf_flag);

  p_cnt_load_r6: assert property (@(posedge clk) disable iff (rst)
    cnt_wr |=> (cnt_q == $past(cnt_wr_val)));

  p_shift_in_r2: assert property (@(posedge clk) disable iff (rst)
    (shift_ev && !dr_wr) |=> (dr_q == {$past(dr_q[DATA_W-2:0]), $past(sdi_s)}));

  p_start_two_wire_r10: assert property (@(posedge clk) disable iff (rst)
    $rose(start_flag) |-> $past(two_wire));
endmodule

bind serial_shift_unit serial_shift_unit_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cnt_ev     (cnt_ev),
  .shift_ev   (shift_ev),
  .sdi_s      (sdi_s),
  .cnt_wr     (cnt_wr),
  .cnt_wr_val (cnt_wr_val),
  .dr_wr      (dr_wr),
  .ovf_clr    (ovf_clr),
  .two_wire   (two_wire),
  .start_flag (start_flag),
  .ovf_flag   (ovf_flag),
  .cnt_q      (cnt_q),
  .dr_q       (dr_q)
);

// File: tb/serial_shift_unit_tb.sv
module serial_shift_unit_tb;
  localparam int DW = 8;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sdi_pin = 1'b1, sck_pin = 1'b0;
  logic two_wire = 1'b0, ext_clk = 1'b1, ext_fall = 1'b0, cnt_soft = 1'b0;
  logic tgl_stb = 1'b0, cnt_wr = 1'b0, dr_wr = 1'b0, ovf_clr = 1'b0, start_clr = 1'b0;
  logic [CW-1:0] cnt_wr_val = '0;
  logic [DW-1:0] dr_wr_val = '0;
  logic sdo, sck_out, sda_low, scl_low, scl_hold, ovf_flag, start_flag;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] dr_q;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  serial_shift_unit u_dut (
    .clk(clk), .rst(rst), .sdi_pin(sdi_pin), .sck_pin(sck_pin),
    .two_wire(two_wire), .ext_clk(ext_clk), .ext_fall(ext_fall),
    .cnt_soft(cnt_soft), .tgl_stb(tgl_stb), .cnt_wr(cnt_wr),
    .cnt_wr_val(cnt_wr_val), .dr_wr(dr_wr), .dr_wr_val(dr_wr_val),
    .ovf_clr(ovf_clr), .start_clr(start_clr), .sdo(sdo), .sck_out(sck_out),
    .sda_low(sda_low), .scl_low(scl_low), .scl_hold(scl_hold),
    .ovf_flag(ovf_flag), .start_flag(start_flag), .cnt_q(cnt_q), .dr_q(dr_q)
  );

  function automatic logic [DW-1:0] shift_model(logic [DW-1:0] cur, logic b);
    return {cur[DW-2:0], b};
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pin_edge(logic lvl);
    sck_pin = lvl;
    tick(5);
  endtask

  task automatic pin_bit(logic b);
    sdi_pin = b;
    tick(3);
    pin_edge(1'b1);
    pin_edge(1'b0);
  endtask

  task automatic toggle();
    tgl_stb = 1'b1; tick(1); tgl_stb = 1'b0;
  endtask

  task automatic load_cnt(logic [CW-1:0] v);
    cnt_wr = 1'b1; cnt_wr_val = v; tick(1); cnt_wr = 1'b0;
  endtask

  task automatic load_dr(logic [DW-1:0] v);
    dr_wr = 1'b1; dr_wr_val = v; tick(1); dr_wr = 1'b0;
  endtask

  task automatic clear_ovf();
    ovf_clr = 1'b1; tick(1); ovf_clr = 1'b0;
  endtask

  task automatic clear_start();
    start_clr = 1'b1; tick(1); start_clr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] b, exp_dr;
    void'($urandom(32'h1234_5EED));
    tick(4);
    rst = 1'b0;
    tick(1);
    // R1 reset state
    chk("R1 dr", int'(dr_q), 0);
    chk("R1 cnt", int'(cnt_q), 0);
    chk("R1 flags", int'({ovf_flag, start_flag}), 0);
    chk("R1 outs", int'({sdo, sck_out, sda_low, scl_low, scl_hold}), 0);

    // R2 R3 R4 R5 R12: random bytes in three-wire pin-clock mode
    for (int i = 0; i < 20; i++) begin
      b = DW'($urandom);
      exp_dr = dr_q;
      for (int k = DW - 1; k >= 0; k--) begin
        pin_bit(b[k]);
        exp_dr = shift_model(exp_dr, b[k]);
        if (i == 0 && k == DW - 3) chk("R3 cnt after 3 pulses", int'(cnt_q), 6);
      end
      chk("R2 byte", int'(dr_q), int'(exp_dr));
      chk("R12 sdo", int'(sdo), int'(b[DW-1]));
      chk("R12 sda three-wire", int'(sda_low), 0);
      chk("R3 cnt wraps to 0", int'(cnt_q), 0);
      chk("R4 ovf", int'(ovf_flag), 1);
      chk("R11 no hold three-wire", int'({scl_hold, scl_low}), 0);
      clear_ovf();
      chk("R5 ovf cleared", int'(ovf_flag), 0);
    end

    // R6 R4 preset
    load_cnt(4'hF);
    chk("R6 load", int'(cnt_q), 15);
    pin_edge(1'b1);
    chk("R4 preset wrap cnt", int'(cnt_q), 0);
    chk("R4 preset wrap ovf", int'(ovf_flag), 1);
    pin_edge(1'b0);
    clear_ovf();

    // R5 set beats clear, R6 load beats count (software clock)
    ext_clk = 1'b0;
    tick(1);
    load_cnt(4'hF);
    tgl_stb = 1'b1; ovf_clr = 1'b1; tick(1); tgl_stb = 1'b0; ovf_clr = 1'b0;
    chk("R5 set wins", int'(ovf_flag), 1);
    chk("R4 wrap sw", int'(cnt_q), 0);
    tgl_stb = 1'b1; cnt_wr = 1'b1; cnt_wr_val = 4'd5; tick(1);
    tgl_stb = 1'b0; cnt_wr = 1'b0;
    chk("R6 load beats count", int'(cnt_q), 5);
    chk("R7 sck_out back low", int'(sck_out), 0);

    // R7 software clocked byte
    load_dr('0);
    load_cnt('0);
    clear_ovf();
    b = DW'($urandom);
    for (int k = DW - 1; k >= 0; k--) begin
      sdi_pin = b[k];
      tick(3);
      toggle();
      if (k == DW - 1) begin
        chk("R7 sck_out high", int'(sck_out), 1);
        chk("R7 count per toggle", int'(cnt_q), 1);
      end
      toggle();
    end
    chk("R7 byte", int'(dr_q), int'(b));
    chk("R7 cnt", int'(cnt_q), 0);
    chk("R7 ovf", int'(ovf_flag), 1);
    clear_ovf();

    // R8 counter-only strobe with pin clock
    ext_clk = 1'b1; cnt_soft = 1'b1;
    tick(1);
    load_cnt(4'd3);
    exp_dr = dr_q;
    toggle();
    chk("R8 cnt by strobe", int'(cnt_q), 4);
    chk("R8 sck_out unchanged", int'(sck_out), 0);
    chk("R8 dr unchanged", int'(dr_q), int'(exp_dr));
    pin_bit(1'b1);
    chk("R8 pin shifts", int'(dr_q), int'(shift_model(exp_dr, 1'b1)));
    chk("R8 pin not counted", int'(cnt_q), 4);
    cnt_soft = 1'b0;

    // R13 falling-edge shift
    ext_fall = 1'b1;
    load_dr('0);
    sdi_pin = 1'b1;
    tick(3);
    pin_edge(1'b1);
    chk("R13 no shift on rise", int'(dr_q), 0);
    pin_edge(1'b0);
    chk("R13 shift on fall", int'(dr_q), 1);
    ext_fall = 1'b0;

    // R9 R11 R12 two-wire
    two_wire = 1'b1;
    load_dr('0);
    load_cnt('0);
    clear_ovf();
    b = DW'($urandom) | 8'h01;
    b[DW-1] = 1'b0;
    exp_dr = '0;
    for (int k = DW - 1; k >= 0; k--) begin
      pin_bit(b[k]);
      exp_dr = shift_model(exp_dr, b[k]);
    end
    chk("R9 same data two-wire", int'(dr_q), int'(exp_dr));
    chk("R12 sda_low", int'(sda_low), 1);
    chk("R12 sdo", int'(sdo), 0);
    chk("R11 hold on ovf", int'({scl_hold, scl_low}), 3);
    chk("R10 no false start", int'(start_flag), 0);
    clear_ovf();
    chk("R11 release", int'({scl_hold, scl_low}), 0);

    // R10 start condition
    sdi_pin = 1'b1; tick(3);
    pin_edge(1'b1);
    sdi_pin = 1'b0; tick(5);
    chk("R10 start set", int'(start_flag), 1);
    chk("R11 hold on start", int'(scl_hold), 1);
    clear_start();
    chk("R10 start cleared", int'(start_flag), 0);
    pin_edge(1'b0);
    clear_ovf();

    two_wire = 1'b0;
    sdi_pin = 1'b1; tick(3);
    pin_edge(1'b1);
    sdi_pin = 1'b0; tick(5);
    chk("R10 no start three-wire", int'(start_flag), 0);
    chk("R11 no scl_low three-wire", int'(scl_low), 0);
    pin_edge(1'b0);

    // R14 data load
    load_dr(8'hA5);
    chk("R14 dr load", int'(dr_q), 8'hA5);
    chk("R12 sdo after load", int'(sdo), 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule